// File: doc/BRIEF.md
# Configurable Serial Result Shifter

This block is the output half of a serial converter port. It takes a 12-bit-plus-sign conversion result, or a 9-bit status word, and shifts it out on one data line. The word is framed by an active-low chip select and clocked by a serial clock. The shape of a result word comes from three controls: the data length (8, 12 or 16 bits), whether a sign bit is added, and the bit order. Six word lengths come from one shifter: 8, 12 and 16 bits unsigned, and 9, 13 and 17 bits signed. The status word always leaves least significant bit first.

All logic runs on a single system clock. Chip select and serial clock are sampled as levels on that clock, and the block acts on their edges. On the clock after chip select is seen low following a high sample, the block captures the word and format and presents the first bit. Each later falling serial-clock edge moves to the next bit. When the word is used up, the line holds at zero. Raising chip select ends the frame at once, and the next frame restarts from its first bit. The result and status inputs are plain levels, sampled only at frame start. There is no stream handshake, because the word is presented by the converter and is not consumed in flow.

Top module: `res_serializer`

## Requirements
- R1: While reset (rst_n low) is asserted, and until the first chip-select fall, sdo_oe and sdo are both 0.
- R2: sdo_oe is 1 exactly on the cycles that follow a cycle with cs_n sampled low, and 0 after a cycle with cs_n high. While sdo_oe is 0, sdo is 0.
- R3: One cycle after cs_n is first sampled low, sdo carries bit 0 of the frame. Each falling serial-clock edge (sclk sampled 1 then 0 while cs_n is low) advances one bit. A rising sclk edge leaves sdo unchanged.
- R4: The length code fmt_len selects the data length: 0 gives 8 bits, 1 gives 12 bits, 2 gives 16 bits, and 3 is treated as 12. With fmt_signed=0 and fmt_msb_first=1, 16-bit output is four zeros and then res_word[11:0] from bit 11 down. 12-bit output is res_word[11:0] from bit 11 down.
- R5: With fmt_signed=1 and fmt_msb_first=1, the sign bit res_word[12] is sent first. In 17-bit output, five sign copies precede res_word[11:0]. In 13-bit and 9-bit output, one sign bit precedes the magnitude.
- R6: With fmt_msb_first=0 the word is the exact reverse of the MSB-first word. The magnitude LSB goes first, padding follows the magnitude MSB, and in signed formats the final bit is the sign.
- R7: An 8-bit length sends res_word[11:4], with res_word[11] as the magnitude MSB.
- R8: With sel_status=1 the 9 bits of stat_word go out bit 0 first, whatever the format controls say.
- R9: After the last bit of the word, sdo stays 0 for all further serial-clock edges until cs_n rises.
- R10: Raising cs_n part way through a frame aborts it. The next chip-select fall starts again from bit 0 of a newly captured word.
- R11: Word and format inputs are captured at the chip-select fall. Later changes to them do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, sampled on clk |
| sclk | input | 1 | Serial clock, sampled on clk; falling edge advances |
| res_word | input | 13 | Conversion result: bit 12 sign, bits 11:0 magnitude |
| stat_word | input | 9 | Status word, sent bit 0 first |
| fmt_len | input | 2 | Data length code (0:8, 1:12, 2:16, 3:12) |
| fmt_signed | input | 1 | Add sign bit to the word |
| fmt_msb_first | input | 1 | 1 = most significant first, 0 = least significant first |
| sel_status | input | 1 | 1 = send status word instead of result |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (high-impedance when 0) |

## Verification
On every cycle, assertions check how the enable follows chip select, that the line is quiet while the enable is low, and that the bit index restarts at a frame start. They also check that the index holds with no falling serial edge, never passes the captured length, and gives zeros past the end of the word. Only the bench scenarios can show that each of the six lengths, in both orders and with status selected, comes out in the right bit order and padding. The same holds for an aborted frame restarting cleanly and for inputs that change mid-frame being ignored.

// File: rtl/res_ser_pkg.sv
package res_ser_pkg;
  localparam int MAG_W   = 12;
  localparam int SHORT_W = 8;
  localparam int PAD_W   = 4;
  localparam int STAT_W  = 9;

  typedef enum logic [1:0] {
    LEN_SHORT = 2'd0,
    LEN_MID   = 2'd1,
    LEN_LONG  = 2'd2,
    LEN_ALT   = 2'd3
  } len_sel_e;
endpackage

// File: rtl/res_ser_edges.sv
module res_ser_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic frame_start,
  output logic shift_pulse
);
  logic cs_q;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  assign frame_start = cs_q & ~cs_n;
  assign shift_pulse = sclk_q & ~sclk & ~cs_n;

  assert_start_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !cs_n);
endmodule

// File: rtl/res_ser_build.sv
module res_ser_build #(
  parameter int MAG_W   = res_ser_pkg::MAG_W,
  parameter int SHORT_W = res_ser_pkg::SHORT_W,
  parameter int PAD_W   = res_ser_pkg::PAD_W,
  parameter int STAT_W  = res_ser_pkg::STAT_W,
  localparam int FRAME_W = MAG_W + PAD_W + 1,
  localparam int IDX_W   = $clog2(FRAME_W + 1)
) (
  input  logic [MAG_W:0]      res_word,
  input  logic [STAT_W-1:0]   stat_word,
  input  res_ser_pkg::len_sel_e fmt_len,
  input  logic                fmt_signed,
  input  logic                fmt_msb_first,
  input  logic                sel_status,
  output logic [FRAME_W-1:0]  frame,
  output logic [IDX_W-1:0]    frame_len
);
  import res_ser_pkg::*;

  logic [MAG_W-1:0]   core;
  logic [IDX_W-1:0]   core_w;
  logic [IDX_W-1:0]   total;
  logic               pad_bit;
  logic [FRAME_W-1:0] lsb_view;
  logic [FRAME_W-1:0] msb_view;

  always_comb begin
    core    = res_word[MAG_W-1:0];
    core_w  = IDX_W'(MAG_W);
    if (fmt_len == LEN_SHORT) begin
      core   = MAG_W'(res_word[MAG_W-1 -: SHORT_W]);
      core_w = IDX_W'(SHORT_W);
    end
    total = core_w + IDX_W'(fmt_signed);
    if (fmt_len == LEN_LONG) total = total + IDX_W'(PAD_W);
    pad_bit = fmt_signed & res_word[MAG_W];
  end

  // word in natural order (least significant first), then mirrored view
  for (genvar g = 0; g < FRAME_W; g++) begin : g_bit
    localparam logic [IDX_W-1:0] POS = IDX_W'(g);
    logic [IDX_W-1:0] mirror;
    always_comb begin
      if (POS < core_w)     lsb_view[g] = (g < MAG_W) ? core[g % MAG_W] : 1'b0;
      else if (POS < total) lsb_view[g] = pad_bit;
      else                  lsb_view[g] = 1'b0;
    end
    assign mirror = total - 1'b1 - POS;
    assign msb_view[g] = (POS < total) ? lsb_view[mirror] : 1'b0;
  end

  always_comb begin
    if (sel_status) begin
      frame     = FRAME_W'(stat_word);
      frame_len = IDX_W'(STAT_W);
    end else begin
      frame     = fmt_msb_first ? msb_view : lsb_view;
      frame_len = total;
    end
  end
endmodule

// File: rtl/res_ser_core.sv
module res_ser_core #(
  parameter int FRAME_W = 17,
  localparam int IDX_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               frame_start,
  input  logic               shift_pulse,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [IDX_W-1:0]   len_in,
  output logic               sdo,
  output logic               sdo_oe
);
  logic               active;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   len_q;
  logic [FRAME_W-1:0] frame_q;
  logic               in_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      len_q   <= '0;
      frame_q <= '0;
    end else if (cs_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (frame_start) begin
      active  <= 1'b1;
      idx     <= '0;
      len_q   <= len_in;
      frame_q <= frame_in;
    end else if (shift_pulse && active && idx < len_q) begin
      idx <= idx + 1'b1;
    end
  end

  assign in_word = active && (idx < len_q);
  assign sdo     = in_word ? frame_q[idx] : 1'b0;
  assign sdo_oe  = active;

  assert_oe_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);
  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  assert_restart_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (idx == '0 && sdo_oe));
  assert_hold_without_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !frame_start && !shift_pulse) |=> $stable(idx));
  assert_idx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= len_q);
  assert_tail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && idx == len_q) |-> !sdo);
endmodule

// File: rtl/res_serializer.sv
module res_serializer #(
  parameter int MAG_W   = res_ser_pkg::MAG_W,
  parameter int SHORT_W = res_ser_pkg::SHORT_W,
  parameter int PAD_W   = res_ser_pkg::PAD_W,
  parameter int STAT_W  = res_ser_pkg::STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [MAG_W:0]    res_word,
  input  logic [STAT_W-1:0] stat_word,
  input  logic [1:0]        fmt_len,
  input  logic              fmt_signed,
  input  logic              fmt_msb_first,
  input  logic              sel_status,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int FRAME_W = MAG_W + PAD_W + 1;
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  logic               frame_start;
  logic               shift_pulse;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   frame_len;

  res_ser_edges u_edges (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .frame_start (frame_start),
    .shift_pulse (shift_pulse)
  );

  res_ser_build #(
    .MAG_W   (MAG_W),
    .SHORT_W (SHORT_W),
    .PAD_W   (PAD_W),
    .STAT_W  (STAT_W)
  ) u_build (
    .res_word      (res_word),
    .stat_word     (stat_word),
    .fmt_len       (res_ser_pkg::len_sel_e'(fmt_len)),
    .fmt_signed    (fmt_signed),
    .fmt_msb_first (fmt_msb_first),
    .sel_status    (sel_status),
    .frame         (frame),
    .frame_len     (frame_len)
  );

  res_ser_core #(
    .FRAME_W (FRAME_W)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .frame_start (frame_start),
    .shift_pulse (shift_pulse),
    .frame_in    (frame),
    .len_in      (frame_len),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe)
  );
endmodule

// File: tb/test_res_serializer.sv
module test_res_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [12:0] res_word = '0;
  logic [8:0]  stat_word = '0;
  logic [1:0]  fmt_len = '0;
  logic        fmt_signed = 1'b0;
  logic        fmt_msb_first = 1'b1;
  logic        sel_status = 1'b0;
  logic        sdo;
  logic        sdo_oe;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  res_serializer i_res_serializer (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .res_word(res_word), .stat_word(stat_word), .fmt_len(fmt_len),
    .fmt_signed(fmt_signed), .fmt_msb_first(fmt_msb_first),
    .sel_status(sel_status), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // expected word, transmit order: w[0] goes first
  function automatic logic [16:0] expect_word(input logic [12:0] r, input logic [1:0] l,
      input logic sg, input logic mf, input logic st, output int n);
    logic [16:0] w = '0;
    logic [16:0] m = '0;
    int k, lead, p;
    if (st) begin
      n = 9;
      for (int i = 0; i < 9; i++) w[i] = stat_word[i];
      return w;
    end
    k = (l == 2'd0) ? 8 : 12;
    lead = ((l == 2'd2) ? 4 : 0) + (sg ? 1 : 0);
    n = k + lead;
    p = 0;
    for (int i = 0; i < lead; i++) begin m[p] = sg ? r[12] : 1'b0; p++; end
    for (int i = 11; i > 11 - k; i--) begin m[p] = r[i]; p++; end
    for (int i = 0; i < n; i++) w[i] = mf ? m[i] : m[n - 1 - i];
    return w;
  endfunction

  task automatic cs_fall();
    @(negedge clk) cs_n = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic cs_rise();
    @(negedge clk) cs_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic sclk_cycle(input bit check_rise, input logic held);
    @(negedge clk) sclk = 1'b1;
    @(posedge clk); #1;
    if (check_rise) check("R3 rising edge holds bit", sdo, held);
    @(negedge clk) sclk = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic run_frame(input string req, input logic [12:0] r, input logic [1:0] l,
      input logic sg, input logic mf, input logic st);
    int n;
    logic [16:0] w;
    res_word = r; fmt_len = l; fmt_signed = sg; fmt_msb_first = mf; sel_status = st;
    w = expect_word(r, l, sg, mf, st, n);
    cs_fall();
    check("R2 enable after select", sdo_oe, 1'b1);
    for (int i = 0; i < n; i++) begin
      check(req, sdo, w[i]);
      if (i < n - 1) sclk_cycle(i == 0, w[i]);
      else sclk_cycle(1'b0, 1'b0);
    end
    check("R9 tail zero", sdo, 1'b0);
    sclk_cycle(1'b0, 1'b0);
    check("R9 tail zero again", sdo, 1'b0);
    cs_rise();
    check("R2 enable off", sdo_oe, 1'b0);
    check("R2 quiet line", sdo, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 reset oe", sdo_oe, 1'b0);
    check("R1 reset sdo", sdo, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R1 idle oe", sdo_oe, 1'b0);
  endtask

  task automatic t_formats();
    run_frame("R4 unsigned 12 msb", 13'h0A5C, 2'd1, 1'b0, 1'b1, 1'b0);
    run_frame("R4 unsigned 16 msb", 13'h0FA3, 2'd2, 1'b0, 1'b1, 1'b0);
    run_frame("R4 code 3 as 12", 13'h0C39, 2'd3, 1'b0, 1'b1, 1'b0);
    run_frame("R7 unsigned 8 msb", 13'h0B6F, 2'd0, 1'b0, 1'b1, 1'b0);
    run_frame("R5 signed 17 msb", 13'h1321, 2'd2, 1'b1, 1'b1, 1'b0);
    run_frame("R5 signed 13 msb", 13'h1E07, 2'd1, 1'b1, 1'b1, 1'b0);
    run_frame("R5 signed 9 msb", 13'h12A0, 2'd0, 1'b1, 1'b1, 1'b0);
    run_frame("R6 unsigned 16 lsb", 13'h0F01, 2'd2, 1'b0, 1'b0, 1'b0);
    run_frame("R6 signed 17 lsb", 13'h1035, 2'd2, 1'b1, 1'b0, 1'b0);
    run_frame("R6 signed 13 lsb", 13'h1801, 2'd1, 1'b1, 1'b0, 1'b0);
    run_frame("R7 signed 9 lsb", 13'h1C3F, 2'd0, 1'b1, 1'b0, 1'b0);
    stat_word = 9'h14B;
    run_frame("R8 status lsb first", 13'h1FFF, 2'd2, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_abort();
    res_word = 13'h0F00; fmt_len = 2'd1; fmt_signed = 1'b0; fmt_msb_first = 1'b1;
    sel_status = 1'b0;
    cs_fall();
    sclk_cycle(1'b0, 1'b0);
    sclk_cycle(1'b0, 1'b0);
    check("R10 mid frame bit", sdo, 1'b1);
    cs_rise();
    check("R10 abort drops enable", sdo_oe, 1'b0);
    res_word = 13'h0000;
    cs_fall();
    check("R10 restart at bit 0", sdo, 1'b0);
    sclk_cycle(1'b0, 1'b0);
    check("R10 restart second bit", sdo, 1'b0);
    cs_rise();
  endtask

  task automatic t_capture();
    res_word = 13'h0800; fmt_len = 2'd1; fmt_signed = 1'b0; fmt_msb_first = 1'b1;
    sel_status = 1'b0;
    cs_fall();
    check("R11 first bit", sdo, 1'b1);
    @(negedge clk) begin
      res_word = 13'h07FF; fmt_msb_first = 1'b0; sel_status = 1'b1; stat_word = 9'h1FF;
    end
    @(posedge clk); #1;
    check("R11 bit kept after change", sdo, 1'b1);
    sclk_cycle(1'b0, 1'b0);
    check("R11 second bit from captured word", sdo, 1'b0);
    cs_rise();
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    t_reset();
    t_formats();
    t_abort();
    t_capture();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule